// File: doc/BRIEF.md
# Bus Activity Watermark Monitor

The block turns a stream of bus activity pulses into one weighted count per sampling period. It also keeps an exponential moving average of those counts. A free-running tick input, normally one pulse per millisecond, sets the time base. A programmable number of ticks closes each period. Each activity pulse adds a programmable weight to the open count.

When a period closes, the block compares its count against an upper and a lower raw watermark. Two run counters track how many periods in a row have breached each watermark. A run that reaches its programmed window length raises a status flag and then turns its own enable off. The freshly updated average is compared against a separate pair of average watermarks. A single interrupt line carries every status flag that software has enabled.

Software configures and reads the block through a simple word-addressed register port. Writes take effect on the clock edge. Reads are combinational from the selected register.

Top module: `bus_act_wmark_mon`

## Requirements
- R1: After reset every register reads zero except the weight register, which reads 1024, and irq is low.
- R2: With control bits 31 (monitor on) and 18 (periodic sampling) both set, a period closes on the (P+1)-th tick, where P is the period register. The closed count is the sum of the weight register over every event pulse seen since the previous close.
- R3: At each close the average becomes avg - (avg >> (K+1)) + (count >> (K+1)), where K is control field [12:10]. The result is read back at word address 8.
- R4: A write to the seed register (address 4) loads the running average, and the new value reads back on the next cycle.
- R5: With control bit 30 set, the upper run counter counts closed periods whose count is strictly greater than the upper watermark (address 2). When the run reaches control field [28:26] plus one, status bit 31 sets, the run restarts, and control bit 30 clears.
- R6: With control bit 29 set, the lower run counter counts closed periods whose count is strictly less than the lower watermark (address 3). When the run reaches control field [25:23] plus one, status bit 30 sets, the run restarts, and control bit 29 clears.
- R7: A closed period that does not breach a watermark restarts that watermark's run from zero.
- R8: At each close, status bit 29 sets if the new average is above the average-upper register (address 5). Status bit 28 sets if the new average is below the average-lower register (address 6).
- R9: A write to the status register (address 9) clears each status bit written as one. Writing all ones clears all of them.
- R10: irq is high exactly when at least one of these status/enable pairs is set: status 31 with control 30, status 30 with control 29, status 29 with control 21, or status 28 with control 20.
- R11: While control bit 31 or bit 18 is clear, no period closes. Ticks and events are ignored, and the average, status and run state stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base pulse, one per sampling unit |
| event_i | input | 1 | Bus activity pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address for writes |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register word address for reads |
| rd_data | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Masked OR of the status flags |

## Verification
Register writes, average updates, status flags and control-bit self-clears all land on the clock edge that samples them. That edge is either the write edge or the edge where the (P+1)-th tick is taken. The read port and irq follow those registers with no added delay. The bench drives all inputs on falling edges and holds the tick low between periods, so the timer cannot advance while results are inspected. It reads every result at the falling edge right after the closing edge, which is the first point where that close is visible.

// File: rtl/bawm_pkg.sv
package bawm_pkg;
  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int FLD_W = 3;

  localparam logic [AW-1:0] A_PERIOD = 4'd0;
  localparam logic [AW-1:0] A_CTRL   = 4'd1;
  localparam logic [AW-1:0] A_RAW_HI = 4'd2;
  localparam logic [AW-1:0] A_RAW_LO = 4'd3;
  localparam logic [AW-1:0] A_SEED   = 4'd4;
  localparam logic [AW-1:0] A_AVG_HI = 4'd5;
  localparam logic [AW-1:0] A_AVG_LO = 4'd6;
  localparam logic [AW-1:0] A_WEIGHT = 4'd7;
  localparam logic [AW-1:0] A_AVG    = 4'd8;
  localparam logic [AW-1:0] A_STAT   = 4'd9;

  localparam int C_K_LSB     = 10;
  localparam int C_PERIODIC  = 18;
  localparam int C_AVG_LO_IE = 20;
  localparam int C_AVG_HI_IE = 21;
  localparam int C_LOWIN_LSB = 23;
  localparam int C_HIWIN_LSB = 26;
  localparam int C_CON_LO_IE = 29;
  localparam int C_CON_HI_IE = 30;
  localparam int C_ON        = 31;

  // status flags live in bits 31..28 of the status word
  localparam int S_LSB = 28;

  localparam logic [DW-1:0] DEF_WEIGHT = 32'd1024;
endpackage

// File: rtl/bawm_sampler.sv
module bawm_sampler #(
  parameter int PER_W = 16,
  parameter int CW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             event_i,
  input  logic [PER_W-1:0] period,
  input  logic [CW-1:0]    weight,
  output logic             close_o,
  output logic [CW-1:0]    total_o
);
  logic [PER_W-1:0] tcnt_q;
  logic [CW-1:0]    acc_q;

  always_comb begin
    total_o = acc_q + (event_i ? weight : '0);
    close_o = run && tick && (tcnt_q == period);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      tcnt_q <= '0;
      acc_q  <= '0;
    end else if (close_o) begin
      tcnt_q <= '0;
      acc_q  <= '0;
    end else begin
      if (tick) tcnt_q <= tcnt_q + 1'b1;
      acc_q <= total_o;
    end
  end
endmodule

// File: rtl/bawm_ema.sv
module bawm_ema #(
  parameter int W  = 32,
  parameter int KW = 3
) (
  input  logic [W-1:0]  avg_i,
  input  logic [W-1:0]  cnt_i,
  input  logic [KW-1:0] k_i,
  output logic [W-1:0]  avg_o
);
  logic [KW:0] sh;
  always_comb begin
    sh    = {1'b0, k_i} + 1'b1;
    avg_o = avg_i - (avg_i >> sh) + (cnt_i >> sh);
  end
endmodule

// File: rtl/bawm_breach.sv
module bawm_breach #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          close,
  input  logic          hit,
  input  logic [FW-1:0] win_m1,
  output logic          fire_o
);
  localparam int RW = FW + 1;
  logic [RW-1:0] run_q;
  logic [RW-1:0] nxt;
  logic [RW-1:0] win;

  always_comb begin
    nxt    = run_q + 1'b1;
    win    = {1'b0, win_m1} + 1'b1;
    fire_o = en && close && hit && (nxt == win);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en)         run_q <= '0;
    else if (close) begin
      if (!hit || fire_o)      run_q <= '0;
      else                     run_q <= nxt;
    end
  end
endmodule

// File: rtl/bus_act_wmark_mon.sv
module bus_act_wmark_mon
  import bawm_pkg::*;
#(
  parameter int PER_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          event_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int NB = 2; // 0: upper run, 1: lower run

  logic [PER_W-1:0] period_q;
  logic [DW-1:0]    ctrl_q, raw_hi_q, raw_lo_q, seed_q, avg_hi_q, avg_lo_q, weight_q, avg_q;
  logic [3:0]       stat_q;

  logic             run_w, close_w;
  logic [DW-1:0]    total_w, avg_nx;
  logic [NB-1:0]    fire_w, hit_w, en_w;
  logic [FLD_W-1:0] win_w [NB];
  logic [3:0]       set_w, clr_w;

  function automatic logic wsel(input logic [AW-1:0] a);
    return wr_en && (wr_addr == a);
  endfunction

  assign run_w = ctrl_q[C_ON] && ctrl_q[C_PERIODIC];

  bawm_sampler #(.PER_W(PER_W), .CW(DW)) smp_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_i), .event_i(event_i),
    .period(period_q), .weight(weight_q), .close_o(close_w), .total_o(total_w)
  );

  bawm_ema #(.W(DW), .KW(FLD_W)) ema_i (
    .avg_i(avg_q), .cnt_i(total_w), .k_i(ctrl_q[C_K_LSB +: FLD_W]), .avg_o(avg_nx)
  );

  always_comb begin
    hit_w[0] = total_w > raw_hi_q;
    hit_w[1] = total_w < raw_lo_q;
    en_w[0]  = ctrl_q[C_CON_HI_IE];
    en_w[1]  = ctrl_q[C_CON_LO_IE];
    win_w[0] = ctrl_q[C_HIWIN_LSB +: FLD_W];
    win_w[1] = ctrl_q[C_LOWIN_LSB +: FLD_W];
  end

  for (genvar g = 0; g < NB; g++) begin : g_run
    bawm_breach #(.FW(FLD_W)) brc_i (
      .clk(clk), .rst_n(rst_n), .en(en_w[g]), .close(close_w),
      .hit(hit_w[g]), .win_m1(win_w[g]), .fire_o(fire_w[g])
    );
  end

  always_comb begin
    set_w = {fire_w[0], fire_w[1], close_w && (avg_nx > avg_hi_q), close_w && (avg_nx < avg_lo_q)};
    clr_w = wsel(A_STAT) ? wr_data[S_LSB +: 4] : 4'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0; ctrl_q <= '0; raw_hi_q <= '0; raw_lo_q <= '0;
      seed_q <= '0; avg_hi_q <= '0; avg_lo_q <= '0; weight_q <= DEF_WEIGHT;
      avg_q <= '0; stat_q <= '0;
    end else begin
      if (wsel(A_PERIOD)) period_q <= wr_data[PER_W-1:0];
      if (wsel(A_RAW_HI)) raw_hi_q <= wr_data;
      if (wsel(A_RAW_LO)) raw_lo_q <= wr_data;
      if (wsel(A_AVG_HI)) avg_hi_q <= wr_data;
      if (wsel(A_AVG_LO)) avg_lo_q <= wr_data;
      if (wsel(A_WEIGHT)) weight_q <= wr_data;
      if (wsel(A_CTRL)) ctrl_q <= wr_data;
      else begin
        if (fire_w[0]) ctrl_q[C_CON_HI_IE] <= 1'b0;
        if (fire_w[1]) ctrl_q[C_CON_LO_IE] <= 1'b0;
      end
      if (wsel(A_SEED)) begin
        seed_q <= wr_data;
        avg_q  <= wr_data;
      end else if (close_w) begin
        avg_q  <= avg_nx;
      end
      stat_q <= (stat_q & ~clr_w) | set_w;
    end
  end

  always_comb begin
    case (rd_addr)
      A_PERIOD: rd_data = DW'(period_q);
      A_CTRL:   rd_data = ctrl_q;
      A_RAW_HI: rd_data = raw_hi_q;
      A_RAW_LO: rd_data = raw_lo_q;
      A_SEED:   rd_data = seed_q;
      A_AVG_HI: rd_data = avg_hi_q;
      A_AVG_LO: rd_data = avg_lo_q;
      A_WEIGHT: rd_data = weight_q;
      A_AVG:    rd_data = avg_q;
      A_STAT:   rd_data = {stat_q, {S_LSB{1'b0}}};
      default:  rd_data = '0;
    endcase
    irq = |(stat_q & {ctrl_q[C_CON_HI_IE], ctrl_q[C_CON_LO_IE], ctrl_q[C_AVG_HI_IE], ctrl_q[C_AVG_LO_IE]});
  end
endmodule

// File: rtl/bawm_checker.sv
module bawm_checker
  import bawm_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          irq,
  input logic [DW-1:0] ctrl_q,
  input logic [DW-1:0] avg_q,
  input logic [3:0]    stat_q,
  input logic          close_w
);
  // R2
  close_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_w |-> (ctrl_q[C_ON] && ctrl_q[C_PERIODIC] && tick_i));

  // R11
  avg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[C_ON] && !(wr_en && wr_addr == A_SEED)) |=> $stable(avg_q));

  // R9
  stat_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STAT && wr_data == '1 && !close_w) |=> (stat_q == 4'b0));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q == 4'b0) |-> !irq);

  // R5
  hi_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_q[3]) && !$past(wr_en && wr_addr == A_CTRL)) |-> !ctrl_q[C_CON_HI_IE]);

  // R6
  lo_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stat_q[2]) && !$past(wr_en && wr_addr == A_CTRL)) |-> !ctrl_q[C_CON_LO_IE]);
endmodule

bind bus_act_wmark_mon bawm_checker chk_i (.*);

// File: tb/bus_act_wmark_mon_tb_top.sv
`timescale 1ns/1ps
module bus_act_wmark_mon_tb_top;
  localparam int P = 7;

  logic        clk = 0, rst_n = 0, tick_i = 0, event_i = 0, wr_en = 0;
  logic [3:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic        irq;

  int checks = 0, fails = 0;
  logic [31:0] e_ctrl = 0, e_avg = 0, e_hi = 0, e_lo = 0, e_ahi = 0, e_alo = 0, e_w = 1024;
  logic [3:0]  e_stat = 0;
  int          r_hi = 0, r_lo = 0;

  always #5 clk = ~clk;

  bus_act_wmark_mon dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      4'd1: begin e_ctrl = d; if (!d[30]) r_hi = 0; if (!d[29]) r_lo = 0; end
      4'd2: e_hi = d;
      4'd3: e_lo = d;
      4'd4: e_avg = d;
      4'd5: e_ahi = d;
      4'd6: e_alo = d;
      4'd7: e_w = d;
      4'd9: e_stat = e_stat & ~d[31:28];
      default: ;
    endcase
  endtask

  // one sampling period of P+1 ticks with n events (n <= P)
  task automatic period(input int n);
    logic [31:0] c;
    int k;
    for (int i = 0; i <= P; i++) begin
      tick_i = 1; event_i = (i < n);
      @(negedge clk);
    end
    tick_i = 0; event_i = 0;
    if (e_ctrl[31] && e_ctrl[18]) begin
      c = n * e_w;
      k = e_ctrl[12:10] + 1;
      e_avg = e_avg - (e_avg >> k) + (c >> k);
      if (e_ctrl[30] && c > e_hi) begin
        r_hi++;
        if (r_hi == e_ctrl[28:26] + 1) begin e_stat[3] = 1; e_ctrl[30] = 0; r_hi = 0; end
      end else r_hi = 0;
      if (e_ctrl[29] && c < e_lo) begin
        r_lo++;
        if (r_lo == e_ctrl[25:23] + 1) begin e_stat[2] = 1; e_ctrl[29] = 0; r_lo = 0; end
      end else r_lo = 0;
      if (e_avg > e_ahi) e_stat[1] = 1;
      if (e_avg < e_alo) e_stat[0] = 1;
    end
  endtask

  task automatic verify(input string tag);
    logic [31:0] v;
    logic ei;
    rd(4'd8, v);  chk(v == e_avg, {tag, " avg"}, v, e_avg);
    rd(4'd9, v);  chk(v == {e_stat, 28'b0}, {tag, " status"}, v, {e_stat, 28'b0});
    rd(4'd1, v);  chk(v == e_ctrl, {tag, " ctrl"}, v, e_ctrl);
    ei = (e_stat[3] & e_ctrl[30]) | (e_stat[2] & e_ctrl[29]) | (e_stat[1] & e_ctrl[21]) | (e_stat[0] & e_ctrl[20]);
    chk(irq == ei, {tag, " irq R10"}, {31'b0, irq}, {31'b0, ei});
  endtask

  function automatic logic [31:0] cfg(input int k, input int hw, input int lw, input logic [7:0] bits);
    // bits: {on, periodic, avg_hi_ie, avg_lo_ie, con_hi_ie, con_lo_ie, 2'b0}
    return (32'(bits[7]) << 31) | (32'(bits[6]) << 18) | (32'(bits[5]) << 21) | (32'(bits[4]) << 20)
         | (32'(bits[3]) << 30) | (32'(bits[2]) << 29) | (32'(k) << 10) | (32'(hw) << 26) | (32'(lw) << 23);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk(v == ((a == 7) ? 32'd1024 : 32'd0), "R1 reset reg", v, (a == 7) ? 32'd1024 : 32'd0);
    end
    chk(irq == 0, "R1 irq", {31'b0, irq}, 0);

    wr(4'd0, P);
    wr(4'd7, 16);
    wr(4'd2, 32'd1000);
    wr(4'd5, 32'hFFFF_FFFF);

    // R2 R3 R4: average sweep over K and event counts
    for (int k = 0; k < 4; k++) begin
      wr(4'd4, 32'd64 + 32'(k * 8));
      rd(4'd8, v); chk(v == e_avg, "R4 seed readback", v, e_avg);
      wr(4'd1, cfg(k, 0, 0, 8'b1100_0000));
      for (int n = 0; n <= P; n++) begin
        period(n);
        verify("R2/R3");
      end
    end

    // R11: monitor off, then periodic off
    wr(4'd1, cfg(0, 0, 0, 8'b0100_0000));
    period(5); verify("R11 off");
    wr(4'd1, cfg(0, 0, 0, 8'b1000_0000));
    period(6); verify("R11 nonperiodic");

    // R5 R7: upper runs, window sweep, break patterns
    wr(4'd2, 32'd48);
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 3; p++) begin
        logic [7:0] pat;
        pat = (p == 0) ? 8'hFF : (p == 1) ? 8'b1101_1011 : 8'b1110_1111;
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd1, cfg(0, w, 0, 8'b1100_1000));
        for (int i = 0; i < 8; i++) begin
          period(pat[i] ? 4 : 2);
          verify("R5/R7 upper");
        end
      end
    end

    // R6 R7: lower runs
    wr(4'd2, 32'd1000);
    wr(4'd3, 32'd40);
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 3; p++) begin
        logic [7:0] pat;
        pat = (p == 0) ? 8'hFF : (p == 1) ? 8'b1011_0111 : 8'b0111_1110;
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd1, cfg(1, 0, w, 8'b1100_0100));
        for (int i = 0; i < 8; i++) begin
          period(pat[i] ? 1 : 5);
          verify("R6/R7 lower");
        end
      end
    end

    // R9 full clear
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd9, v); chk(v == 0, "R9 clear all", v, 0);

    // R8 R10 R9: average watermarks, masking, partial clear
    wr(4'd3, 32'd0);
    wr(4'd5, 32'd50);
    wr(4'd6, 32'd20);
    wr(4'd4, 32'd40);
    wr(4'd1, cfg(0, 0, 0, 8'b1100_0000));
    period(7); verify("R8 avg above masked");
    wr(4'd1, cfg(0, 0, 0, 8'b1110_0000));
    verify("R10 avg above unmasked");
    for (int i = 0; i < 4; i++) begin period(0); verify("R8 avg falling"); end
    wr(4'd1, cfg(0, 0, 0, 8'b1111_0000));
    verify("R10 both");
    wr(4'd9, 32'h2000_0000);
    verify("R9 partial clear");
    wr(4'd9, 32'h1000_0000);
    verify("R9 second clear");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule